// File: doc/BRIEF.md
# Start-of-Transmission Sequence Monitor for a Serial Display Data Lane

This block sits beside one data lane of a low-power/high-speed serial display link and watches two things: the digitised single-ended low-power line levels and a flag that shows the lane is in high-speed mode. Before every high-speed burst, a transmitter must leave the stop state (both lines high), drive the request state (positive line low, negative high) and then the bridge state (both low). Only after that may it start the burst. The monitor times these steps with a free-running sampling clock of known period. It classifies every entry into high speed as good, short or failed, and it raises a sticky flicker-suspect flag when the low plateau is missing altogether.

Two durations are measured, both in ticks and reported in nanoseconds as ticks times the tick period. The low plateau counts the samples spent in the request or bridge state. The exit duration counts every sample after the lane leaves the stop state. Each measurement begins on the first sample that is not the stop state and ends on the first sample that shows high-speed activity. Saturating counters keep a tally of good, short and failed entries and of order errors. The last plateau and exit values are held on outputs.

Top module: `sot_monitor`

## Requirements
- R1: While reset is held and directly after it, all four event counters, both duration outputs, the event outputs and the flicker flag read zero.
- R2: Lane code is {lp_p, lp_n}: 2'b11 stop, 2'b01 request, 2'b00 bridge, 2'b10 illegal. The plateau is the number of request/bridge samples from leaving stop to the first sample with hs_active high, reported as ticks × TICK_PS/1000 ns. An entry whose plateau is at least MIN_NS (13 ticks at 4000 ps) has class 2'd0 (good) and increments good_cnt.
- R3: A plateau that is non-zero but shorter than MIN_NS gives class 2'd1 (short) and increments short_cnt.
- R4: A zero plateau, including stop followed directly by high speed, gives class 2'd2 (failed), increments fail_cnt and sets flicker_suspect, which stays high until reset.
- R5: The exit duration counts all non-stop samples before high speed. When it is shorter than MIN_NS, ev_exit_warn is high alongside the event.
- R6: High-speed activity that is not preceded by a stop sample (for example a lane held continuously in high speed) produces no event and changes no counter.
- R7: Any order other than stop, request, bridge, then high speed raises ev_seq_err with the event and increments seq_err_cnt. This covers an illegal state, bridge before request, request after bridge, and high speed before any bridge sample. The entry is still classified.
- R8: A return to stop during a measurement pulses ev_seq_err with ev_valid low, increments seq_err_cnt and restarts the measurement from the next exit.
- R9: Event counters stop at 2^CNT_W−1 and do not wrap.
- R10: Duration counts stop at 2^DUR_W−1 ticks (1020 ns with defaults).
- R11: ev_valid and the event fields are valid for exactly one cycle, in the cycle after the first high-speed sample is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, one tick per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_p | input | 1 | Digitised low-power level of the positive line |
| lp_n | input | 1 | Digitised low-power level of the negative line |
| hs_active | input | 1 | Lane is in high-speed mode |
| ev_valid | output | 1 | One-cycle strobe for a classified entry |
| ev_class | output | 2 | 0 good, 1 short, 2 failed |
| ev_exit_warn | output | 1 | Exit duration below minimum |
| ev_seq_err | output | 1 | Order error or aborted measurement |
| flicker_suspect | output | 1 | Sticky: a zero plateau was seen |
| good_cnt | output | CNT_W | Good entries |
| short_cnt | output | CNT_W | Short entries |
| fail_cnt | output | CNT_W | Failed entries |
| seq_err_cnt | output | CNT_W | Order errors and aborts |
| last_plateau_ns | output | NS_W | Last plateau in ns |
| last_exit_ns | output | NS_W | Last exit duration in ns |

## Verification
The hardest situations to reach are the ones where the measurement window is cut short or starts in an odd way. These are a return to stop in the middle of the plateau, an exit through the illegal state, and a zero plateau that still has non-zero exit time. The stimulus table builds each of these from explicit counts of illegal, request and bridge samples. A directed case then aborts a measurement and follows it at once with a clean entry, to show that the old ticks are discarded. Saturation is reached with an instance whose counter width has been narrowed, and with a plateau longer than the duration counter can hold.

// File: rtl/sot_mon_pkg.sv
package sot_mon_pkg;
  typedef enum logic [1:0] {
    LANE_BRIDGE = 2'b00,
    LANE_REQ    = 2'b01,
    LANE_ODD    = 2'b10,
    LANE_STOP   = 2'b11
  } lane_e;

  typedef enum logic [1:0] {
    MON_WAIT  = 2'd0,
    MON_ARMED = 2'd1,
    MON_MEAS  = 2'd2,
    MON_BURST = 2'd3
  } mon_state_e;

  typedef enum logic [1:0] {
    ORD_REQ    = 2'd0,
    ORD_BRIDGE = 2'd1,
    ORD_BAD    = 2'd2
  } ord_e;

  typedef enum logic [1:0] {
    CLS_GOOD  = 2'd0,
    CLS_SHORT = 2'd1,
    CLS_FAIL  = 2'd2
  } cls_e;
endpackage

// File: rtl/sot_sat_counter.sv
module sot_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         load_one,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (load)                        count_d = {{(W-1){1'b0}}, load_one};
    else if (inc && count_q != MAX)  count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;

  // R9 / R10: a full counter holds its value
  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count_q == MAX) |=> count_q == MAX);

  // R9 / R10: without a load the count never goes down
  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> count_q >= $past(count_q));
endmodule

// File: rtl/sot_seq_fsm.sv
module sot_seq_fsm
  import sot_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lane,
  input  logic       hs,
  output logic       start,
  output logic       start_low,
  output logic       tick_inc,
  output logic       low_inc,
  output logic       done,
  output logic       direct,
  output logic       order_err,
  output logic       abort
);
  mon_state_e state_q, state_d;
  ord_e       ord_q, ord_d;
  lane_e      lane_s;
  logic       lane_low;

  assign lane_s   = lane_e'(lane);
  assign lane_low = (lane_s == LANE_REQ) || (lane_s == LANE_BRIDGE);

  always_comb begin
    state_d   = state_q;
    ord_d     = ord_q;
    start     = 1'b0;
    start_low = 1'b0;
    tick_inc  = 1'b0;
    low_inc   = 1'b0;
    done      = 1'b0;
    direct    = 1'b0;
    order_err = 1'b0;
    abort     = 1'b0;
    case (state_q)
      MON_WAIT: begin
        if (!hs && lane_s == LANE_STOP) state_d = MON_ARMED;
      end
      MON_ARMED: begin
        if (hs) begin
          done    = 1'b1;
          direct  = 1'b1;
          state_d = MON_BURST;
        end else if (lane_s != LANE_STOP) begin
          start     = 1'b1;
          start_low = lane_low;
          ord_d     = (lane_s == LANE_REQ) ? ORD_REQ : ORD_BAD;
          state_d   = MON_MEAS;
        end
      end
      MON_MEAS: begin
        if (hs) begin
          done      = 1'b1;
          order_err = (ord_q != ORD_BRIDGE);
          state_d   = MON_BURST;
        end else if (lane_s == LANE_STOP) begin
          abort   = 1'b1;
          state_d = MON_ARMED;
        end else begin
          tick_inc = 1'b1;
          low_inc  = lane_low;
          case (ord_q)
            ORD_REQ: begin
              if (lane_s == LANE_BRIDGE)   ord_d = ORD_BRIDGE;
              else if (lane_s != LANE_REQ) ord_d = ORD_BAD;
            end
            ORD_BRIDGE: begin
              if (lane_s != LANE_BRIDGE) ord_d = ORD_BAD;
            end
            default: ord_d = ORD_BAD;
          endcase
        end
      end
      default: begin
        if (!hs) state_d = MON_WAIT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MON_WAIT;
      ord_q   <= ORD_REQ;
    end else begin
      state_q <= state_d;
      ord_q   <= ord_d;
    end
  end

  // R6: a burst is only ever classified once, from the armed or measuring state
  assert_burst_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/sot_monitor.sv
module sot_monitor
  import sot_mon_pkg::*;
#(
  parameter int TICK_PS = 4000,
  parameter int MIN_NS  = 50,
  parameter int DUR_W   = 8,
  parameter int CNT_W   = 16,
  parameter int NS_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_p,
  input  logic             lp_n,
  input  logic             hs_active,
  output logic             ev_valid,
  output logic [1:0]       ev_class,
  output logic             ev_exit_warn,
  output logic             ev_seq_err,
  output logic             flicker_suspect,
  output logic [CNT_W-1:0] good_cnt,
  output logic [CNT_W-1:0] short_cnt,
  output logic [CNT_W-1:0] fail_cnt,
  output logic [CNT_W-1:0] seq_err_cnt,
  output logic [NS_W-1:0]  last_plateau_ns,
  output logic [NS_W-1:0]  last_exit_ns
);
  localparam int MIN_TICKS = (MIN_NS * 1000 + TICK_PS - 1) / TICK_PS;
  localparam int N_EVC     = 4;

  logic             start, start_low, tick_inc, low_inc;
  logic             done, direct, order_err, abort;
  logic [DUR_W-1:0] exit_cnt, low_cnt, plat_t, exit_t;
  logic             plat_short, exit_short;
  cls_e             cls_d;
  logic [N_EVC-1:0] ev_inc;
  logic [CNT_W-1:0] ev_cnt [N_EVC];

  logic             valid_q, valid_d;
  logic [1:0]       class_q, class_d;
  logic             warn_q, warn_d;
  logic             serr_q, serr_d;
  logic             flick_q, flick_d;
  logic [NS_W-1:0]  plat_ns_q, plat_ns_d, exit_ns_q, exit_ns_d;

  function automatic logic [NS_W-1:0] to_ns(input logic [DUR_W-1:0] t);
    logic [63:0] prod;
    prod  = 64'(t) * 64'(TICK_PS);
    return NS_W'(prod / 64'd1000);
  endfunction

  sot_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane      ({lp_p, lp_n}),
    .hs        (hs_active),
    .start     (start),
    .start_low (start_low),
    .tick_inc  (tick_inc),
    .low_inc   (low_inc),
    .done      (done),
    .direct    (direct),
    .order_err (order_err),
    .abort     (abort)
  );

  sot_sat_counter #(.W(DUR_W)) u_exit_ticks (
    .clk(clk), .rst_n(rst_n), .load(start), .load_one(1'b1),
    .inc(tick_inc), .count(exit_cnt)
  );

  sot_sat_counter #(.W(DUR_W)) u_low_ticks (
    .clk(clk), .rst_n(rst_n), .load(start), .load_one(start_low),
    .inc(low_inc), .count(low_cnt)
  );

  always_comb begin
    plat_t     = direct ? '0 : low_cnt;
    exit_t     = direct ? '0 : exit_cnt;
    plat_short = ({{(32-DUR_W){1'b0}}, plat_t} < 32'(MIN_TICKS));
    exit_short = ({{(32-DUR_W){1'b0}}, exit_t} < 32'(MIN_TICKS));
    if (plat_t == '0)    cls_d = CLS_FAIL;
    else if (plat_short) cls_d = CLS_SHORT;
    else                 cls_d = CLS_GOOD;
    ev_inc[0] = done && (cls_d == CLS_GOOD);
    ev_inc[1] = done && (cls_d == CLS_SHORT);
    ev_inc[2] = done && (cls_d == CLS_FAIL);
    ev_inc[3] = (done && order_err) || abort;
  end

  for (genvar g = 0; g < N_EVC; g++) begin : g_evc
    sot_sat_counter #(.W(CNT_W)) u_evc (
      .clk(clk), .rst_n(rst_n), .load(1'b0), .load_one(1'b0),
      .inc(ev_inc[g]), .count(ev_cnt[g])
    );
  end

  always_comb begin
    valid_d   = done;
    class_d   = done ? cls_d : class_q;
    warn_d    = done && exit_short;
    serr_d    = (done && order_err) || abort;
    flick_d   = flick_q || (done && plat_t == '0);
    plat_ns_d = done ? to_ns(plat_t) : plat_ns_q;
    exit_ns_d = done ? to_ns(exit_t) : exit_ns_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      class_q   <= 2'd0;
      warn_q    <= 1'b0;
      serr_q    <= 1'b0;
      flick_q   <= 1'b0;
      plat_ns_q <= '0;
      exit_ns_q <= '0;
    end else begin
      valid_q   <= valid_d;
      class_q   <= class_d;
      warn_q    <= warn_d;
      serr_q    <= serr_d;
      flick_q   <= flick_d;
      plat_ns_q <= plat_ns_d;
      exit_ns_q <= exit_ns_d;
    end
  end

  assign ev_valid        = valid_q;
  assign ev_class        = valid_q ? class_q : 2'd0;
  assign ev_exit_warn    = warn_q;
  assign ev_seq_err      = serr_q;
  assign flicker_suspect = flick_q;
  assign good_cnt        = ev_cnt[0];
  assign short_cnt       = ev_cnt[1];
  assign fail_cnt        = ev_cnt[2];
  assign seq_err_cnt     = ev_cnt[3];
  assign last_plateau_ns = plat_ns_q;
  assign last_exit_ns    = exit_ns_q;

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> !ev_valid);

  assert_flicker_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flicker_suspect |=> flicker_suspect);

  assert_fail_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_class == 2'd2) |-> (last_plateau_ns == '0 && flicker_suspect));

  assert_short_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_class == 2'd1) |-> last_plateau_ns != '0);

  assert_exit_covers_plateau_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> last_exit_ns >= last_plateau_ns);
endmodule

// File: tb/test_sot_monitor.sv
`timescale 1ns/1ps
module test_sot_monitor;
  localparam int CW   = 4;
  localparam int CMAX = 15;
  localparam int DMAX = 255;
  localparam int MINT = 13;

  typedef struct packed {
    int       n10;
    int       n01;
    int       n00;
    bit       rev;
    bit [1:0] cls;
    bit       ew;
    bit       se;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{0, 5, 10, 1'b0, 2'd0, 1'b0, 1'b0},
    '{0, 3, 10, 1'b0, 2'd0, 1'b0, 1'b0},
    '{0, 2, 10, 1'b0, 2'd1, 1'b1, 1'b0},
    '{0, 0, 0,  1'b0, 2'd2, 1'b1, 1'b0},
    '{0, 16, 0, 1'b0, 2'd0, 1'b0, 1'b1},
    '{0, 0, 14, 1'b0, 2'd0, 1'b0, 1'b1},
    '{0, 10, 5, 1'b1, 2'd0, 1'b0, 1'b1},
    '{2, 1, 1,  1'b0, 2'd1, 1'b1, 1'b1},
    '{3, 0, 0,  1'b0, 2'd2, 1'b1, 1'b1},
    '{0, 40, 60, 1'b0, 2'd0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n, lp_p, lp_n, hs_active;
  logic ev_valid, ev_exit_warn, ev_seq_err, flicker_suspect;
  logic [1:0] ev_class;
  logic [CW-1:0] good_cnt, short_cnt, fail_cnt, seq_err_cnt;
  logic [15:0] last_plateau_ns, last_exit_ns;

  int checks = 0, failures = 0, ev_seen = 0;
  int e_good = 0, e_short = 0, e_fail = 0, e_seq = 0;
  bit timed_out = 1'b0;

  always #2 clk = ~clk;

  sot_monitor #(.CNT_W(CW)) i_sot_monitor (
    .clk(clk), .rst_n(rst_n), .lp_p(lp_p), .lp_n(lp_n), .hs_active(hs_active),
    .ev_valid(ev_valid), .ev_class(ev_class), .ev_exit_warn(ev_exit_warn),
    .ev_seq_err(ev_seq_err), .flicker_suspect(flicker_suspect),
    .good_cnt(good_cnt), .short_cnt(short_cnt), .fail_cnt(fail_cnt),
    .seq_err_cnt(seq_err_cnt), .last_plateau_ns(last_plateau_ns),
    .last_exit_ns(last_exit_ns)
  );

  always @(negedge clk) if (ev_valid) ev_seen++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit p, input bit n, input bit h);
    @(negedge clk);
    lp_p = p; lp_n = n; hs_active = h;
  endtask

  task automatic sat_inc(ref int v);
    if (v < CMAX) v++;
  endtask

  task automatic check_counts(input string req);
    chk(req, "good_cnt", int'(good_cnt), e_good);
    chk(req, "short_cnt", int'(short_cnt), e_short);
    chk(req, "fail_cnt", int'(fail_cnt), e_fail);
    chk(req, "seq_err_cnt", int'(seq_err_cnt), e_seq);
  endtask

  task automatic do_entry(input int n10, input int n01, input int n00, input bit rev);
    for (int i = 0; i < 3; i++) drive(1, 1, 0);
    for (int i = 0; i < n10; i++) drive(1, 0, 0);
    if (!rev) begin
      for (int i = 0; i < n01; i++) drive(0, 1, 0);
      for (int i = 0; i < n00; i++) drive(0, 0, 0);
    end else begin
      for (int i = 0; i < n00; i++) drive(0, 0, 0);
      for (int i = 0; i < n01; i++) drive(0, 1, 0);
    end
    drive(0, 0, 1);
  endtask

  task automatic check_event(input int n10, input int n01, input int n00,
                             input int cls, input bit ew, input bit se);
    int pt, et;
    string rq;
    pt = (n01 + n00 > DMAX) ? DMAX : n01 + n00;
    et = (n10 + n01 + n00 > DMAX) ? DMAX : n10 + n01 + n00;
    rq = (cls == 0) ? "R2" : (cls == 1) ? "R3" : "R4";
    if (cls == 0) sat_inc(e_good);
    else if (cls == 1) sat_inc(e_short);
    else sat_inc(e_fail);
    if (se) sat_inc(e_seq);
    @(negedge clk);
    chk("R11", "ev_valid", int'(ev_valid), 1);
    chk(rq, "ev_class", int'(ev_class), cls);
    chk("R5", "ev_exit_warn", int'(ev_exit_warn), int'(ew));
    chk("R7", "ev_seq_err", int'(ev_seq_err), int'(se));
    chk((pt == DMAX) ? "R10" : "R2", "last_plateau_ns", int'(last_plateau_ns), pt * 4);
    chk((et == DMAX) ? "R10" : "R5", "last_exit_ns", int'(last_exit_ns), et * 4);
    check_counts(rq);
    if (cls == 2) chk("R4", "flicker_suspect", int'(flicker_suspect), 1);
    @(negedge clk);
    chk("R11", "ev_valid_after", int'(ev_valid), 0);
    drive(0, 0, 0);
  endtask

  task automatic run_all();
    int snap;
    // R1: reset state
    rst_n = 1'b0; lp_p = 1'b1; lp_n = 1'b1; hs_active = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "flicker_in_reset", int'(flicker_suspect), 0);
    chk("R1", "plateau_in_reset", int'(last_plateau_ns), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_counts("R1");
    chk("R1", "ev_valid", int'(ev_valid), 0);
    chk("R1", "exit_after_reset", int'(last_exit_ns), 0);
    chk("R1", "flicker_after_reset", int'(flicker_suspect), 0);

    // Table of entries (R2, R3, R4, R5, R7)
    for (int v = 0; v < NV; v++) begin
      do_entry(VECS[v].n10, VECS[v].n01, VECS[v].n00, VECS[v].rev);
      check_event(VECS[v].n10, VECS[v].n01, VECS[v].n00,
                  int'(VECS[v].cls), VECS[v].ew, VECS[v].se);
    end

    // R6: continuous high speed with no stop state before it
    snap = ev_seen;
    for (int i = 0; i < 40; i++) drive(0, 0, 1);
    drive(0, 0, 0);
    for (int i = 0; i < 30; i++) drive(0, 0, 1);
    drive(0, 1, 0);
    @(negedge clk);
    chk("R6", "events_during_hs", ev_seen - snap, 0);
    check_counts("R6");

    // R8: abort by return to stop, then a clean entry
    for (int i = 0; i < 3; i++) drive(1, 1, 0);
    for (int i = 0; i < 3; i++) drive(0, 1, 0);
    drive(1, 1, 0);
    @(negedge clk);
    sat_inc(e_seq);
    chk("R8", "abort_seq_err", int'(ev_seq_err), 1);
    chk("R8", "abort_ev_valid", int'(ev_valid), 0);
    chk("R8", "abort_seq_cnt", int'(seq_err_cnt), e_seq);
    do_entry(0, 5, 10, 1'b0);
    check_event(0, 5, 10, 0, 1'b0, 1'b0);

    // R10: plateau longer than the tick counter range
    do_entry(0, 100, 200, 1'b0);
    check_event(0, 100, 200, 0, 1'b0, 1'b0);

    // R9: event counter saturation
    for (int k = 0; k < 9; k++) begin
      do_entry(0, 6, MINT, 1'b0);
      check_event(0, 6, MINT, 0, 1'b0, 1'b0);
    end
    chk("R9", "good_saturated", int'(good_cnt), CMAX);

    // R1: reset clears everything again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    e_good = 0; e_short = 0; e_fail = 0; e_seq = 0;
    @(negedge clk);
    check_counts("R1");
    chk("R1", "flicker_cleared", int'(flicker_suspect), 0);
    chk("R1", "plateau_cleared", int'(last_plateau_ns), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule